// File: doc/BRIEF.md
# Per-Process Idle-Threshold Predictor Store

This block keeps the adaptive idle thresholds that a memory rank power controller uses to decide when an idle rank may drop into a low-power state. It keeps one threshold for each rank. Between process switches, each threshold learns from the idle gaps reported for its rank. When an idle gap closes before the threshold was reached, the threshold was too eager and doubles. When a rank went to low power and then stayed idle for more than twice its threshold, the threshold was too timid and halves. Every threshold stays between a minimum and a maximum.

The operating system announces each process switch with a one-cycle strobe, together with the identifier of the process that is leaving and the identifier of the process that is arriving. The block copies the live thresholds into a small on-chip table under the identifier of the leaving process. It then loads the entry stored for the arriving process, or a default set when no entry exists for it. In this way each process's thresholds are learned only from its own idle behaviour.

When the table is full and a new identifier must be stored, the block replaces entries in round-robin order. A ready output is low while a swap is in progress. During that time new strobes and idle-gap reports are ignored.

Top module: `ctx_thr_store`

## Requirements
- R1: After reset, `ready` is 1, every rank threshold equals `TH_DEFAULT`, and the table holds no entries.
- R2: With `ready` high, a report on a rank with `evt_lp`=0 and `evt_gap` strictly below that rank's threshold sets the threshold to min(2×threshold, `TH_MAX`). The new value is visible one cycle later.
- R3: With `ready` high, a report on a rank with `evt_lp`=1 and `evt_gap` strictly above 2×threshold sets the threshold to max(threshold/2, `TH_MIN`), using integer halving. The new value is visible one cycle later.
- R4: Any other report leaves the threshold unchanged. This covers `evt_lp`=0 with the gap at or above the threshold, and `evt_lp`=1 with the gap at or below twice the threshold.
- R5: A strobe accepted with `cs_in_pid` ≠ `cs_out_pid` drives `ready` low for exactly two cycles after the sampling edge. The restored thresholds appear on `thr_out` in the cycle in which `ready` returns high.
- R6: The thresholds saved under an identifier are restored unchanged when that identifier is next the incoming one, provided its entry has not been replaced.
- R7: An incoming identifier with no table entry loads `TH_DEFAULT` into every rank.
- R8: A strobe with `cs_in_pid` = `cs_out_pid` leaves the thresholds unchanged and keeps `ready` high.
- R9: While `ready` is low, strobes and idle-gap reports have no effect.
- R10: Saving an identifier that is not yet in the table uses the next slot in round-robin order, starting at slot 0 after reset. Once the table is full, this replaces the oldest allocated entry.
- R11: A report on one rank never changes the threshold of another rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_valid | input | 1 | Process-switch strobe, one cycle |
| cs_out_pid | input | PID_W | Identifier of the process that is leaving |
| cs_in_pid | input | PID_W | Identifier of the process that is arriving |
| evt_valid | input | NUM_RANKS | Per-rank report that an idle gap has ended |
| evt_lp | input | NUM_RANKS | Per-rank flag: the rank was in low power during the gap |
| evt_gap | input | NUM_RANKS*TH_W | Per-rank gap length in cycles; rank r uses bits [r*TH_W +: TH_W] |
| ready | output | 1 | High when no swap is in progress |
| thr_out | output | NUM_RANKS*TH_W | Live thresholds; rank r uses bits [r*TH_W +: TH_W] |

## Verification
The bench builds the block with two ranks, 12-bit thresholds, a default of 32, a minimum of 4, a maximum of 256 and only four table slots. With these values, a short walk of idle-gap reports reaches both clamps and both comparison boundaries. A handful of process switches is enough to fill the table and force round-robin eviction. A sequence of six distinct identifiers then shows that evicted processes fall back to defaults while a surviving process keeps its learned values. The same run also covers a strobe issued mid-swap and a switch to the same identifier.

// File: rtl/ctx_thr_pkg.sv
package ctx_thr_pkg;

  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_SAVE = 2'd1,
    SW_LOAD = 2'd2
  } swap_state_e;

  // Gap closed before the threshold with no low-power entry: too eager.
  function automatic logic is_grow(logic [31:0] thr, logic [31:0] gap, logic lp);
    return !lp && (gap < thr);
  endfunction

  // Low power reached and the gap outlasted twice the threshold: too timid.
  function automatic logic is_shrink(logic [31:0] thr, logic [31:0] gap, logic lp);
    logic [32:0] twice;
    twice = {1'b0, thr} << 1;
    return lp && ({1'b0, gap} > twice);
  endfunction

  function automatic logic [31:0] grown(logic [31:0] thr, logic [31:0] hi);
    logic [32:0] twice;
    twice = {1'b0, thr} << 1;
    return (twice > {1'b0, hi}) ? hi : twice[31:0];
  endfunction

  function automatic logic [31:0] shrunk(logic [31:0] thr, logic [31:0] lo);
    return ((thr >> 1) < lo) ? lo : (thr >> 1);
  endfunction

endpackage

// File: rtl/ctx_swap_fsm.sv
module ctx_swap_fsm
  import ctx_thr_pkg::*;
#(
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_valid,
  input  logic [PID_W-1:0] cs_out_pid,
  input  logic [PID_W-1:0] cs_in_pid,
  output logic             ready,
  output logic             save_en,
  output logic             load_en,
  output logic [PID_W-1:0] save_pid,
  output logic [PID_W-1:0] load_pid
);

  swap_state_e state_q;
  logic [PID_W-1:0] out_q, in_q;
  logic start_swap;
  logic busy_strobe;

  assign start_swap  = (state_q == SW_IDLE) && cs_valid && (cs_in_pid != cs_out_pid);
  assign busy_strobe = (state_q != SW_IDLE) && cs_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      out_q   <= '0;
      in_q    <= '0;
    end else begin
      case (state_q)
        SW_IDLE: if (start_swap) begin
          state_q <= SW_SAVE;
          out_q   <= cs_out_pid;
          in_q    <= cs_in_pid;
        end
        SW_SAVE: state_q <= SW_LOAD;
        SW_LOAD: state_q <= SW_IDLE;
        default: state_q <= SW_IDLE;
      endcase
    end
  end

  assign ready    = (state_q == SW_IDLE);
  assign save_en  = (state_q == SW_SAVE);
  assign load_en  = (state_q == SW_LOAD);
  assign save_pid = out_q;
  assign load_pid = in_q;

  AST_SWAP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_swap |=> save_en); // R5
  AST_SAVE_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    save_en |=> load_en); // R5
  AST_LOAD_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> ready); // R5
  AST_BUSY_PIDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_strobe && save_en |=> $stable(load_pid) && $stable(save_pid)); // R9

endmodule

// File: rtl/ctx_thr_table.sv
module ctx_thr_table #(
  parameter int PID_W     = 8,
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PID_W-1:0]  rd_pid,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data
);

  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic [PID_W-1:0]  tag_q  [NUM_SLOTS];
  logic [DATA_W-1:0] data_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] vld_q;
  logic [SLOT_W-1:0] rr_q;

  logic [NUM_SLOTS-1:0] wr_match, rd_match;
  logic [SLOT_W-1:0] wr_idx, rd_idx;
  logic wr_hit;
  logic alloc_ev;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
    assign wr_match[s] = vld_q[s] && (tag_q[s] == wr_pid);
    assign rd_match[s] = vld_q[s] && (tag_q[s] == rd_pid);
  end

  always_comb begin
    wr_idx = '0;
    rd_idx = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (wr_match[s]) wr_idx = SLOT_W'(s);
      if (rd_match[s]) rd_idx = SLOT_W'(s);
    end
  end

  assign wr_hit   = |wr_match;
  assign rd_hit   = |rd_match;
  assign rd_data  = data_q[rd_idx];
  assign alloc_ev = wr_en && !wr_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        tag_q[s]  <= '0;
        data_q[s] <= '0;
      end
    end else if (wr_en) begin
      if (wr_hit) begin
        data_q[wr_idx] <= wr_data;
      end else begin
        data_q[rr_q] <= wr_data;
        tag_q[rr_q]  <= wr_pid;
        vld_q[rr_q]  <= 1'b1;
        rr_q         <= (rr_q == LAST_SLOT) ? '0 : rr_q + 1'b1;
      end
    end
  end

  AST_TAGS_UNIQUE_RD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_match)); // R6
  AST_TAGS_UNIQUE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_match)); // R10
  AST_ALLOC_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ev |=> (rr_q != $past(rr_q)) || (NUM_SLOTS == 1)); // R10
  AST_HIT_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit) |=> $stable(rr_q)); // R10

endmodule

// File: rtl/ctx_thr_rank.sv
module ctx_thr_rank
  import ctx_thr_pkg::*;
#(
  parameter int TH_W       = 16,
  parameter int TH_MIN     = 8,
  parameter int TH_MAX     = 4096,
  parameter int TH_DEFAULT = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            evt_valid,
  input  logic            evt_lp,
  input  logic [TH_W-1:0] evt_gap,
  input  logic            load_en,
  input  logic [TH_W-1:0] load_val,
  output logic [TH_W-1:0] thr
);

  localparam logic [31:0] LO = 32'(TH_MIN);
  localparam logic [31:0] HI = 32'(TH_MAX);

  logic [TH_W-1:0] thr_q;
  logic grow_ev, shrink_ev;
  logic [TH_W-1:0] grow_val, shrink_val;

  assign grow_ev    = enable && evt_valid && is_grow(32'(thr_q), 32'(evt_gap), evt_lp);
  assign shrink_ev  = enable && evt_valid && is_shrink(32'(thr_q), 32'(evt_gap), evt_lp);
  assign grow_val   = TH_W'(grown(32'(thr_q), HI));
  assign shrink_val = TH_W'(shrunk(32'(thr_q), LO));

  always_ff @(posedge clk) begin
    if (!rst_n)          thr_q <= TH_W'(TH_DEFAULT);
    else if (load_en)    thr_q <= load_val;
    else if (grow_ev)    thr_q <= grow_val;
    else if (shrink_ev)  thr_q <= shrink_val;
  end

  assign thr = thr_q;

  AST_THR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(thr_q) >= LO) && (32'(thr_q) <= HI)); // R2
  AST_GROW_NOT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    grow_ev && !load_en |=> thr_q >= $past(thr_q)); // R2
  AST_SHRINK_NOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    shrink_ev && !load_en |=> thr_q <= $past(thr_q)); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !load_en |=> $stable(thr_q)); // R9
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !grow_ev && !shrink_ev && !load_en |=> $stable(thr_q)); // R4

endmodule

// File: rtl/ctx_thr_store.sv
module ctx_thr_store #(
  parameter int NUM_RANKS  = 4,
  parameter int TH_W       = 16,
  parameter int PID_W      = 8,
  parameter int NUM_SLOTS  = 8,
  parameter int TH_MIN     = 8,
  parameter int TH_MAX     = 4096,
  parameter int TH_DEFAULT = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_valid,
  input  logic [PID_W-1:0]          cs_out_pid,
  input  logic [PID_W-1:0]          cs_in_pid,
  input  logic [NUM_RANKS-1:0]      evt_valid,
  input  logic [NUM_RANKS-1:0]      evt_lp,
  input  logic [NUM_RANKS*TH_W-1:0] evt_gap,
  output logic                      ready,
  output logic [NUM_RANKS*TH_W-1:0] thr_out
);

  localparam int DATA_W = NUM_RANKS * TH_W;

  logic save_en, load_en;
  logic [PID_W-1:0] save_pid, load_pid;
  logic rd_hit;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] live;
  logic same_pid_strobe;

  ctx_swap_fsm #(.PID_W(PID_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cs_valid(cs_valid), .cs_out_pid(cs_out_pid), .cs_in_pid(cs_in_pid),
    .ready(ready), .save_en(save_en), .load_en(load_en),
    .save_pid(save_pid), .load_pid(load_pid)
  );

  ctx_thr_table #(.PID_W(PID_W), .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(save_en), .wr_pid(save_pid), .wr_data(live),
    .rd_pid(load_pid), .rd_hit(rd_hit), .rd_data(rd_data)
  );

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic [TH_W-1:0] restore_val;
    assign restore_val = rd_hit ? rd_data[r*TH_W +: TH_W] : TH_W'(TH_DEFAULT);

    ctx_thr_rank #(
      .TH_W(TH_W), .TH_MIN(TH_MIN), .TH_MAX(TH_MAX), .TH_DEFAULT(TH_DEFAULT)
    ) u_rank (
      .clk(clk), .rst_n(rst_n), .enable(ready),
      .evt_valid(evt_valid[r]), .evt_lp(evt_lp[r]),
      .evt_gap(evt_gap[r*TH_W +: TH_W]),
      .load_en(load_en), .load_val(restore_val),
      .thr(live[r*TH_W +: TH_W])
    );
  end

  assign thr_out = live;
  assign same_pid_strobe = ready && cs_valid && (cs_in_pid == cs_out_pid);

  AST_SAME_PID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    same_pid_strobe && (evt_valid == '0) |=> $stable(thr_out) && ready); // R8
  AST_SWAP_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ready && cs_valid && (cs_in_pid != cs_out_pid) |=> !ready); // R5
  AST_MISS_LOADS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    load_en && !rd_hit |=> thr_out[TH_W-1:0] == TH_W'(TH_DEFAULT)); // R7

endmodule

// File: tb/tb_ctx_thr_store.sv
module tb_ctx_thr_store;

  localparam int NR = 2;
  localparam int TW = 12;
  localparam int PW = 4;
  localparam int NS = 4;
  localparam int TMIN = 4;
  localparam int TMAX = 256;
  localparam int TDEF = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_valid = 1'b0;
  logic [PW-1:0] cs_out_pid = '0, cs_in_pid = '0;
  logic [NR-1:0] evt_valid = '0, evt_lp = '0;
  logic [NR*TW-1:0] evt_gap = '0;
  logic ready;
  logic [NR*TW-1:0] thr_out;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  ctx_thr_store #(
    .NUM_RANKS(NR), .TH_W(TW), .PID_W(PW), .NUM_SLOTS(NS),
    .TH_MIN(TMIN), .TH_MAX(TMAX), .TH_DEFAULT(TDEF)
  ) dut (.*);

  // Rank-0 report walk: lp flag, gap, expected threshold afterwards, requirement.
  localparam int VN = 15;
  localparam int V_LP [VN]  = '{0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1, 1, 1, 0};
  localparam int V_GAP[VN]  = '{10, 63, 100, 5, 300, 512, 513, 300, 129, 65, 33, 17, 9, 4, 3};
  localparam int V_EXP[VN]  = '{64, 128, 256, 256, 256, 256, 128, 64, 32, 16, 8, 4, 4, 4, 8};
  localparam int V_REQ[VN]  = '{2, 2, 2, 2, 4, 4, 3, 3, 3, 3, 3, 3, 3, 4, 2};

  function automatic int th(int r);
    return int'(thr_out[r*TW +: TW]);
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report(int r, int lp, int gap);
    @(negedge clk);
    evt_valid[r] = 1'b1;
    evt_lp[r] = lp[0];
    evt_gap[r*TW +: TW] = TW'(gap);
    @(negedge clk);
    evt_valid = '0;
    evt_lp = '0;
    evt_gap = '0;
  endtask

  task automatic do_switch(int outp, int inp, int e0, int e1, string req);
    @(negedge clk);
    cs_valid = 1'b1;
    cs_out_pid = PW'(outp);
    cs_in_pid = PW'(inp);
    @(negedge clk);
    cs_valid = 1'b0;
    check("R5 ready low 1", int'(ready), 0);
    @(negedge clk);
    check("R5 ready low 2", int'(ready), 0);
    @(negedge clk);
    check("R5 ready back", int'(ready), 1);
    check(req, th(0), e0);
    check(req, th(1), e1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", int'(ready), 1);
    check("R1 thr0", th(0), TDEF);
    check("R1 thr1", th(1), TDEF);

    // R2 R3 R4 R11: table-driven walk on rank 0, rank 1 must stay at default.
    for (int i = 0; i < VN; i++) begin
      report(0, V_LP[i], V_GAP[i]);
      check($sformatf("R%0d vec %0d", V_REQ[i], i), th(0), V_EXP[i]);
      check("R11 other rank", th(1), TDEF);
    end
    // process 1 now holds (8, 32)

    do_switch(1, 2, TDEF, TDEF, "R7 new pid defaults");
    report(1, 0, 0);
    check("R2 rank1 grow", th(1), 64);
    check("R11 rank0 held", th(0), TDEF);
    do_switch(2, 1, 8, 32, "R6 restore pid1");
    do_switch(1, 2, 32, 64, "R6 restore pid2");

    // R8: same identifier
    @(negedge clk);
    cs_valid = 1'b1; cs_out_pid = 4'd2; cs_in_pid = 4'd2;
    @(negedge clk);
    cs_valid = 1'b0;
    check("R8 ready stays", int'(ready), 1);
    @(negedge clk);
    check("R8 ready stays 2", int'(ready), 1);
    check("R8 thr0", th(0), 32);
    check("R8 thr1", th(1), 64);

    // R9: second strobe during swap is ignored
    @(negedge clk);
    cs_valid = 1'b1; cs_out_pid = 4'd2; cs_in_pid = 4'd1;
    @(negedge clk);
    cs_out_pid = 4'd1; cs_in_pid = 4'd7;
    evt_valid = 2'b01; evt_lp = '0; evt_gap = '0;
    @(negedge clk);
    cs_valid = 1'b0; evt_valid = '0;
    @(negedge clk);
    check("R9 ready", int'(ready), 1);
    check("R9 thr0", th(0), 8);
    check("R9 thr1", th(1), 32);
    @(negedge clk);
    check("R9 no extra swap", int'(ready), 1);
    check("R9 thr0 kept", th(0), 8);

    // R10: fill four slots and evict in round-robin order
    do_switch(1, 2, 32, 64, "R6 pid2 again");
    do_switch(2, 3, TDEF, TDEF, "R7 pid3");
    report(0, 0, 0);
    do_switch(3, 4, TDEF, TDEF, "R7 pid4");
    report(1, 1, 65);
    check("R3 pid4 rank1", th(1), 16);
    do_switch(4, 5, TDEF, TDEF, "R7 pid5");
    do_switch(5, 6, TDEF, TDEF, "R7 pid6");
    do_switch(6, 1, TDEF, TDEF, "R10 pid1 evicted");
    do_switch(1, 4, TDEF, 16, "R10 pid4 survives");
    do_switch(4, 3, TDEF, TDEF, "R10 pid3 evicted");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule